// File: doc/BRIEF.md
# Row Discriminator Data Serializer

This block turns one row of column-discriminator bits into four serial output lanes. Each lane takes a quarter of the row. Inside a lane, a first multiplexer level picks one bit out of each of several equal groups, which gives slow streams. A second level interleaves those slow streams into one fast stream. The resulting bit order on the fast output is therefore scrambled, and downstream acquisition has to undo it. The slow rate is produced as a cycle enable from the single fast clock, so the whole block works in one clock domain.

An upstream row sequencer pulses `row_vld` once per row slot and presents the row on `row_data`; `start` resynchronises the frame. Two test features can replace rows with content built from two programmable line patterns, and both embed a one-hot frame counter in the top bits of the row:
- A line-marker option appends two such pattern rows to every frame.
- A pattern-only option substitutes pattern rows for every matrix row.

Per-column disable bits force noisy columns to zero. A data strobe shows when a new bit is valid at either speed, and a synchronisation marker controlled by `speak` lets acquisition lock onto frame boundaries.

Top module: `row_serializer`

## Requirements
- R1: After reset, and whenever no row is being serialised, `fast_o`, `slow_o`, `dclk_o` and `mk_o` are all 0.
- R2: A row loaded by `row_vld` appears on the fast lanes from the cycle after the load edge, over 160 cycles (t = 0..159). At cycle t, lane L carries row bit L*160 + (t mod 4)*40 + floor(t/4). During cycles 4k..4k+3, slow stream L*4+s carries row bit L*160 + s*40 + k.
- R3: A matrix row is serialised as `row_data & ~col_dis`, so a set disable bit forces that column to 0.
- R4: With `line_mark_en` high, a frame has NROWS+2 rows. Row index NROWS is `{fcnt, pat0}` and row index NROWS+1 is `{fcnt, pat1}`, with the pattern in bits [629:0] and the 10-bit counter in bits [639:630]. `row_data` is ignored for these rows.
- R5: The frame counter is 0x200 after `start`. It shifts right by one after the last row of each frame has been loaded, so the next frame's pattern rows carry the shifted value.
- R6: With `hs_mode` high, `dclk_o` is 1 on every cycle a row is being serialised. With `hs_mode` low, it is 1 only on cycles where t mod 4 = 0.
- R7: With `pat_only` high, even row indices send `{fcnt, pat0}` and odd row indices send `{fcnt, pat1}`. `row_data` and `col_dis` have no effect in this mode.
- R8: When `speak` is high at any point in a frame, markers are enabled from the next frame. With `mk_mode` 0, `mk_o` pulses only at t = 159 of the frame's last row.
- R9: With `mk_mode` 1 and markers enabled, `mk_o` equals `dclk_o`. With `speak` low, `mk_o` is 0.
- R10: `start` stops any row in progress, sets the row index to 0 and clears marker enables, so the next rows form the first row of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast serial clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Frame resynchronisation pulse |
| row_vld | input | 1 | Row slot strobe; loads the next row |
| row_data | input | ROW_BITS | Discriminator outputs of the current row |
| col_dis | input | ROW_BITS | Per-column disable, 1 forces the column to 0 |
| pat0 | input | ROW_BITS-FCW | Line pattern 0 |
| pat1 | input | ROW_BITS-FCW | Line pattern 1 |
| line_mark_en | input | 1 | Append two pattern rows per frame |
| pat_only | input | 1 | Replace every row with alternating patterns |
| mk_mode | input | 1 | 0: last-bit marker pulse, 1: marker copies the data strobe |
| hs_mode | input | 1 | 1: full-rate data strobe, 0: quarter-rate |
| speak | input | 1 | Marker request |
| fast_o | output | LANES | Fast serial lanes |
| slow_o | output | LANES*MUX2 | First-level slow streams |
| dclk_o | output | 1 | Data strobe |
| mk_o | output | 1 | Frame synchronisation marker |

## Verification
The bench compares every bit of every lane and slow stream against the interleave formula. An implementation that reversed the two multiplexer levels, or emitted bits in plain order, fails on the first random row. It runs line-marker frames back to back to confirm that the counter bits in the appended rows move from 0x200 to 0x100. A counter that shifted at the wrong row, or never reset on `start`, shows the wrong top bits. Marker tests raise `speak` in one frame and expect nothing until the last bit of the following frame's last row, which catches a marker that arms immediately or fires on every row. A mid-frame `start` followed by a full line-marker frame exposes a row index that was not cleared, because the pattern rows then land at the wrong positions.

// File: rtl/row_serializer.sv
module row_serializer #(
  parameter int ROW_BITS = 640,
  parameter int LANES    = 4,
  parameter int MUX2     = 4,
  parameter int NROWS    = 640,
  parameter int FCW      = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic                      row_vld,
  input  logic [ROW_BITS-1:0]       row_data,
  input  logic [ROW_BITS-1:0]       col_dis,
  input  logic [ROW_BITS-FCW-1:0]   pat0,
  input  logic [ROW_BITS-FCW-1:0]   pat1,
  input  logic                      line_mark_en,
  input  logic                      pat_only,
  input  logic                      mk_mode,
  input  logic                      hs_mode,
  input  logic                      speak,
  output logic [LANES-1:0]          fast_o,
  output logic [LANES*MUX2-1:0]     slow_o,
  output logic                      dclk_o,
  output logic                      mk_o
);
  localparam int LANE_BITS = ROW_BITS / LANES;
  localparam int STAGE1    = LANE_BITS / MUX2;
  localparam int CW        = $clog2(LANE_BITS);
  localparam int SW        = $clog2(MUX2);
  localparam int KW        = $clog2(STAGE1);
  localparam int RW        = $clog2(NROWS + 2);
  localparam logic [CW-1:0]  LAST   = CW'(LANE_BITS - 1);
  localparam logic [FCW-1:0] FC_INI = FCW'(1) << (FCW - 1);

  logic [ROW_BITS-1:0] row_q;
  logic [CW-1:0]       cnt;
  logic                active;
  logic [RW-1:0]       rix;
  logic                last_q;
  logic [FCW-1:0]      fcnt;
  logic                seen;
  logic                armed;

  logic [RW-1:0] last_ix;
  logic          is_last, use_pat, pick1, at_end;
  logic [ROW_BITS-1:0] next_row;
  logic [SW-1:0] s_idx;
  logic [KW-1:0] k_idx;

  assign last_ix  = line_mark_en ? RW'(NROWS + 1) : RW'(NROWS - 1);
  assign is_last  = (rix >= last_ix);
  assign use_pat  = pat_only | (rix >= RW'(NROWS));
  assign pick1    = pat_only ? rix[0] : (rix == RW'(NROWS + 1));
  assign next_row = use_pat ? {fcnt, (pick1 ? pat1 : pat0)} : (row_data & ~col_dis);
  assign s_idx    = cnt[SW-1:0];
  assign k_idx    = cnt[SW +: KW];
  assign at_end   = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || start) begin
      row_q  <= '0;
      cnt    <= '0;
      active <= 1'b0;
      rix    <= '0;
      last_q <= 1'b0;
      fcnt   <= FC_INI;
      seen   <= 1'b0;
      armed  <= 1'b0;
    end else begin
      seen <= seen | speak;
      if (row_vld) begin
        row_q  <= next_row;
        cnt    <= '0;
        active <= 1'b1;
        last_q <= is_last;
        rix    <= is_last ? '0 : rix + 1'b1;
        if (is_last) fcnt <= fcnt >> 1;
        if (rix == '0) begin
          armed <= seen;
          seen  <= speak;
        end
      end else if (active) begin
        if (at_end) active <= 1'b0;
        else        cnt    <= cnt + 1'b1;
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_BITS-1:0] lane;
    logic [MUX2-1:0]      st1;
    assign lane = row_q[l*LANE_BITS +: LANE_BITS];
    for (genvar s = 0; s < MUX2; s++) begin : g_grp
      logic [STAGE1-1:0] grp;
      assign grp = lane[s*STAGE1 +: STAGE1];
      assign st1[s] = grp[k_idx];
      assign slow_o[l*MUX2 + s] = active & st1[s];
    end
    assign fast_o[l] = active & st1[s_idx];
  end

  assign dclk_o = active & (hs_mode | (s_idx == '0));
  assign mk_o   = armed & speak &
                  (mk_mode ? dclk_o : (active & last_q & at_end));
endmodule

// File: rtl/row_serializer_chk.sv
module row_serializer_chk #(
  parameter int CW  = 8,
  parameter int FCW = 10,
  parameter int LANE_BITS = 160
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          row_vld,
  input logic          active,
  input logic [CW-1:0] cnt,
  input logic          hs_mode,
  input logic          dclk_o,
  input logic          speak,
  input logic          mk_o,
  input logic          mk_mode,
  input logic [FCW-1:0] fcnt
);
  localparam logic [CW-1:0] LAST = CW'(LANE_BITS - 1);

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !row_vld && !start && cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));

  // R6
  fast_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (active && hs_mode) |-> dclk_o);

  // R9
  mk_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !speak |-> !mk_o);

  // R9
  mk_clock_chk: assert property (@(posedge clk) disable iff (rst)
    (mk_mode && mk_o) |-> dclk_o);

  // R5
  fcnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fcnt));

  // R10
  start_halt_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> !active);
endmodule

bind row_serializer row_serializer_chk #(.CW(CW), .FCW(FCW), .LANE_BITS(LANE_BITS)) chk_i (
  .clk(clk), .rst(rst), .start(start), .row_vld(row_vld), .active(active),
  .cnt(cnt), .hs_mode(hs_mode), .dclk_o(dclk_o), .speak(speak), .mk_o(mk_o),
  .mk_mode(mk_mode), .fcnt(fcnt)
);

// File: tb/row_serializer_tb_top.sv
module row_serializer_tb_top;
  localparam int NR = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, row_vld = 1'b0;
  logic [639:0] row_data = '0, col_dis = '0;
  logic [629:0] pat0 = '0, pat1 = '0;
  logic line_mark_en = 1'b0, pat_only = 1'b0, mk_mode = 1'b0, hs_mode = 1'b1, speak = 1'b0;
  logic [3:0]  fast_o;
  logic [15:0] slow_o;
  logic dclk_o, mk_o;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  row_serializer #(.NROWS(NR)) dut_i (
    .clk(clk), .rst(rst), .start(start), .row_vld(row_vld), .row_data(row_data),
    .col_dis(col_dis), .pat0(pat0), .pat1(pat1), .line_mark_en(line_mark_en),
    .pat_only(pat_only), .mk_mode(mk_mode), .hs_mode(hs_mode), .speak(speak),
    .fast_o(fast_o), .slow_o(slow_o), .dclk_o(dclk_o), .mk_o(mk_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [639:0] rnd_row();
    logic [639:0] r;
    for (int i = 0; i < 20; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  // mk_kind: 0 none, 1 last-bit pulse, 2 copy of strobe
  task automatic run_row(input logic [639:0] exp, input int mk_kind,
                         input string dreq, input string mreq);
    int bad_d = 0, bad_c = 0, bad_m = 0;
    logic [31:0] a_d = 0, e_d = 0, a_c = 0, e_c = 0, a_m = 0, e_m = 0;
    row_data = rnd_row();
    row_vld = 1'b1;
    @(negedge clk);
    row_vld = 1'b0;
    for (int t = 0; t < 160; t++) begin
      logic [3:0]  ef;
      logic [15:0] es;
      logic ec, em;
      for (int l = 0; l < 4; l++) begin
        ef[l] = exp[l*160 + (t % 4)*40 + t/4];
        for (int s = 0; s < 4; s++) es[l*4 + s] = exp[l*160 + s*40 + t/4];
      end
      ec = hs_mode ? 1'b1 : ((t % 4) == 0);
      em = (mk_kind == 1) ? (t == 159) : (mk_kind == 2) ? ec : 1'b0;
      if (fast_o !== ef || slow_o !== es) begin
        bad_d++; a_d = {t[7:0], 4'h0, slow_o, fast_o}; e_d = {t[7:0], 4'h0, es, ef};
      end
      if (dclk_o !== ec) begin bad_c++; a_c = {t, 1'b0} | dclk_o; e_c = {t, 1'b0} | ec; end
      if (mk_o !== em) begin bad_m++; a_m = {t, 1'b0} | mk_o; e_m = {t, 1'b0} | em; end
      @(negedge clk);
    end
    chk(bad_d == 0, dreq, "row data", a_d, e_d);
    chk(bad_c == 0, "R6", "data strobe", a_c, e_c);
    chk(bad_m == 0, mreq, "marker", a_m, e_m);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic idle_chk(input string req);
    chk(fast_o === 4'h0 && slow_o === 16'h0 && dclk_o === 1'b0 && mk_o === 1'b0,
        req, "idle outputs", {fast_o, slow_o, dclk_o, mk_o}, 32'h0);
  endtask

  task automatic t_reset();
    idle_chk("R1");
  endtask

  task automatic t_normal();
    hs_mode = 1'b1; col_dis = '0;
    pulse_start();
    for (int r = 0; r < NR; r++) begin
      logic [639:0] d;
      d = rnd_row();
      row_data = d;
      row_vld = 1'b1; @(negedge clk); row_vld = 1'b0;
      for (int t = 0; t < 160; t++) begin
        logic [3:0] ef;
        for (int l = 0; l < 4; l++) ef[l] = d[l*160 + (t % 4)*40 + t/4];
        if (t == 0 || t == 5 || t == 159)
          chk(fast_o === ef, "R2", "fast lanes", {28'h0, fast_o}, {28'h0, ef});
        @(negedge clk);
      end
    end
    idle_chk("R1");
  endtask

  task automatic t_coldis();
    logic [639:0] dis;
    dis = rnd_row();
    pulse_start();
    for (int r = 0; r < NR; r++) begin
      logic [639:0] d;
      d = rnd_row();
      col_dis = dis;
      row_data = d;
      row_vld = 1'b1; @(negedge clk); row_vld = 1'b0;
      for (int t = 0; t < 160; t++) begin
        logic [3:0] ef;
        for (int l = 0; l < 4; l++) ef[l] = d[l*160 + (t % 4)*40 + t/4] & ~dis[l*160 + (t % 4)*40 + t/4];
        if (fast_o !== ef) chk(1'b0, "R3", "masked lane", {28'h0, fast_o}, {28'h0, ef});
        @(negedge clk);
      end
      chk(1'b1, "R3", "masked row", 0, 0);
    end
    col_dis = '0;
  endtask

  task automatic t_linemark();
    logic [9:0] fc;
    line_mark_en = 1'b1;
    pulse_start();
    fc = 10'h200;
    for (int f = 0; f < 2; f++) begin
      for (int r = 0; r < NR; r++) begin
        logic [639:0] d;
        d = rnd_row();
        row_data = d;
        row_vld = 1'b1; @(negedge clk); row_vld = 1'b0;
        for (int t = 0; t < 160; t++) @(negedge clk);
      end
      run_row({fc, pat0}, 0, "R4", "R8");
      run_row({fc, pat1}, 0, "R5", "R8");
      fc = fc >> 1;
    end
    line_mark_en = 1'b0;
  endtask

  task automatic t_patonly();
    logic [9:0] fc;
    pat_only = 1'b1;
    col_dis = rnd_row();
    pulse_start();
    fc = 10'h200;
    for (int f = 0; f < 2; f++) begin
      for (int r = 0; r < NR; r++)
        run_row({fc, (r % 2) ? pat1 : pat0}, 0, "R7", "R8");
      fc = fc >> 1;
    end
    pat_only = 1'b0;
    col_dis = '0;
  endtask

  task automatic t_slow();
    hs_mode = 1'b0;
    pat_only = 1'b1;
    pulse_start();
    for (int r = 0; r < NR; r++)
      run_row({10'h200, (r % 2) ? pat1 : pat0}, 0, "R2", "R8");
    pat_only = 1'b0;
    hs_mode = 1'b1;
  endtask

  task automatic t_speak();
    logic [9:0] fc;
    pat_only = 1'b1; mk_mode = 1'b0; speak = 1'b1;
    pulse_start();
    fc = 10'h200;
    for (int r = 0; r < NR; r++) run_row({fc, (r % 2) ? pat1 : pat0}, 0, "R7", "R8");
    fc = fc >> 1;
    for (int r = 0; r < NR; r++)
      run_row({fc, (r % 2) ? pat1 : pat0}, (r == NR-1) ? 1 : 0, "R7", "R8");
    fc = fc >> 1;
    mk_mode = 1'b1;
    for (int r = 0; r < NR; r++) run_row({fc, (r % 2) ? pat1 : pat0}, 2, "R7", "R9");
    fc = fc >> 1;
    speak = 1'b0;
    for (int r = 0; r < NR; r++) run_row({fc, (r % 2) ? pat1 : pat0}, 0, "R7", "R9");
    mk_mode = 1'b0; pat_only = 1'b0;
  endtask

  task automatic t_resync();
    line_mark_en = 1'b1;
    pulse_start();
    for (int r = 0; r < 2; r++) begin
      row_data = rnd_row();
      row_vld = 1'b1; @(negedge clk); row_vld = 1'b0;
      for (int t = 0; t < 40; t++) @(negedge clk);
    end
    pulse_start();
    idle_chk("R10");
    for (int r = 0; r < NR; r++) begin
      row_data = rnd_row();
      row_vld = 1'b1; @(negedge clk); row_vld = 1'b0;
      for (int t = 0; t < 160; t++) @(negedge clk);
    end
    run_row({10'h200, pat0}, 0, "R10", "R8");
    run_row({10'h200, pat1}, 0, "R10", "R8");
    line_mark_en = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 20; i++) pat0[i*32 +: 32] = $urandom;
    for (int i = 0; i < 20; i++) pat1[i*32 +: 32] = $urandom;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_normal();
    t_coldis();
    t_linemark();
    t_patonly();
    t_slow();
    t_speak();
    t_resync();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule